// File: doc/BRIEF.md
# Two-Bit Multiplexed Host Port Slave

This block is the slave end of a narrow host bus. The bus carries commands, register addresses and data two bits per clock on a shared pair of data lines, plus one control line. The master raises the control line for the four clocks of a command byte. The slave reassembles that byte and checks the two device-select bits. For register transfers it also collects an address extension byte. After one decode clock it runs a four-clock retry phase. In that phase it either refuses the transfer with a stop signal, says it is ready by pulling the control line low, or lets a wait phase follow.

Data then moves one byte per four-clock phase, with the most significant pair first. The direction is set by the command. Register accesses step their 12-bit address after each byte. FIFO accesses pop one entry per byte. The master asks for a further byte by pulsing the control line in the second clock of a data phase. When a read ends, the slave leaves the data lines undriven for one turnaround clock. On the local side the block offers a register read/write port with a combinational read path and a FIFO pop port.

The shared lines are modelled as separate input, output and output-enable signals, so the pads stay outside the block.

Top module: `hpx_slave`

## Requirements
- R1: A transfer starts when `ctl_i` is high in idle. The command byte arrives over four consecutive clocks with `ctl_i` high, and the pair carrying bits 7:6 comes first. If `ctl_i` goes low in any of the three clocks after the first, the command is abandoned and the block returns to idle without driving anything.
- R2: Command byte fields are as follows. Bits 7:6 are device select and must equal `DEVSEL` (default 2'b01). Bit 5 is 1 for read and 0 for write. Bit 4 is 1 for FIFO and 0 for register. Bits 3:0 are register address bits 11:8. On a device-select mismatch the block drives nothing, raises no local strobe and leaves register contents unchanged.
- R3: A register transfer has a four-clock address phase after the command. Its byte, most significant pair first, forms address bits 7:0. The first byte accesses address `{cmd[3:0], ext}`. A FIFO transfer has no address phase.
- R4: Exactly one decode clock follows the command or address phase. The retry phase then takes the next four clocks, and nothing is driven during decode.
- R5: A FIFO write, or a FIFO read while `fifo_empty_i` is high in the second retry clock, is refused. `stop_o` is high in the third and fourth retry clocks only. No data, ready or local strobe appears, and the block returns to idle. Refusal takes precedence over readiness.
- R6: In the second clock of a retry or wait phase, the block drives the control line low (`ctl_oe_o`=1, `ctl_o`=0) exactly when `loc_busy_i` is low and the transfer is not refused. A data phase follows if it did so; otherwise a wait phase follows.
- R7: For reads, the block drives the byte on `had_o` over the four clocks of a data phase, most significant pair first. It also drives during read wait phases. `had_oe_o` is low at all other times.
- R8: For register writes, the byte taken from the four pairs of a data phase appears on `reg_wdata_o`. It comes with a one-clock `reg_wr_o` pulse in the clock after the last pair, at the current address.
- R9: `ctl_i` high in the second clock of a data phase asks for another byte. The register address then advances by one per byte, across the 8-bit boundary. If `loc_busy_i` is high in the last clock of that data phase, a wait phase comes before the next byte.
- R10: After the last data phase of a read, one turnaround clock with `had_oe_o` low passes before the block is idle again.
- R11: A FIFO read raises `fifo_rd_o` for one clock per byte, in the clock the byte is captured from `fifo_data_i`, and never raises `reg_rd_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| had_i | input | 2 | Shared data pair as seen at the pad |
| had_o | output | 2 | Value the slave drives on the data pair |
| had_oe_o | output | 1 | Output enable for the data pair |
| ctl_i | input | 1 | Control line driven by the master |
| ctl_o | output | 1 | Value the slave drives on the control line (always low) |
| ctl_oe_o | output | 1 | Slave pulls the control line low (ready) |
| stop_o | output | 1 | Transfer refused in retry |
| loc_busy_i | input | 1 | Local side cannot move a byte now |
| reg_addr_o | output | 12 | Register address |
| reg_rd_o | output | 1 | Register read strobe, data taken same clock |
| reg_rdata_i | input | 8 | Register read data |
| reg_wr_o | output | 1 | Register write strobe |
| reg_wdata_o | output | 8 | Register write data |
| fifo_rd_o | output | 1 | FIFO pop strobe, data taken same clock |
| fifo_data_i | input | 8 | FIFO head entry |
| fifo_empty_i | input | 1 | FIFO holds no entry |

## Verification
Refusal and readiness are both decided in the second clock of the retry phase. The bench provokes the overlap with a FIFO read issued while the FIFO model is empty and `loc_busy_i` is low, so both conditions hold in that clock. It judges the outcome by `ctl_oe_o` staying low in that clock, `stop_o` being high in the next two, and no pop or drive appearing. A second overlap is the write strobe of one byte landing in the first clock of the next data or wait phase. That is provoked by multi-byte writes with and without inserted waits, and is judged by a scoreboard that matches every write strobe against the expected address and data.

// File: rtl/hpx_pkg.sv
package hpx_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_ADDR,
        ST_DEC,
        ST_RETRY,
        ST_WAIT,
        ST_DATA,
        ST_TA
    } hpx_state_e;

endpackage

// File: rtl/hpx_pair_shreg.sv
// Byte register moved one pair at a time: shift in at the bottom, present the
// top pair for driving, and offer the byte completed by the incoming pair.
module hpx_pair_shreg #(
    parameter int PAIR_W = 2,
    parameter int BYTE_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [BYTE_W-1:0] load_val_i,
    input  logic              shift_i,
    input  logic [PAIR_W-1:0] pair_i,
    output logic [PAIR_W-1:0] pair_o,
    output logic [BYTE_W-1:0] asm_o
);

    localparam int KEEP_W = BYTE_W - PAIR_W;

    logic [BYTE_W-1:0] word_d, word_q;

    always_comb begin
        word_d = word_q;
        if (load_i) begin
            word_d = load_val_i;
        end else if (shift_i) begin
            word_d = {word_q[KEEP_W-1:0], pair_i};
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            word_q <= '0;
        end else begin
            word_q <= word_d;
        end
    end

    assign pair_o = word_q[BYTE_W-1 -: PAIR_W];
    assign asm_o  = {word_q[KEEP_W-1:0], pair_i};

endmodule

// File: rtl/hpx_addr_ctr.sv
// Register address: loaded from the command and extension bytes, stepped per byte.
module hpx_addr_ctr #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_i,
    input  logic [ADDR_W-1:0] load_val_i,
    input  logic              inc_i,
    output logic [ADDR_W-1:0] addr_o
);

    logic [ADDR_W-1:0] addr_d, addr_q;

    always_comb begin
        addr_d = addr_q;
        if (load_i) begin
            addr_d = load_val_i;
        end else if (inc_i) begin
            addr_d = addr_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            addr_q <= '0;
        end else begin
            addr_q <= addr_d;
        end
    end

    assign addr_o = addr_q;

endmodule

// File: rtl/hpx_cmd_dec.sv
// Field split of the latched command byte and the refusal rule.
module hpx_cmd_dec #(
    parameter int          BYTE_W = 8,
    parameter int          ADDR_W = 12,
    parameter logic [1:0]  DEVSEL = 2'b01
) (
    input  logic [BYTE_W-1:0]        cmd_i,
    input  logic                     fifo_empty_i,
    output logic                     sel_o,
    output logic                     read_o,
    output logic                     fifo_o,
    output logic [ADDR_W-BYTE_W-1:0] hi_o,
    output logic                     refuse_o
);

    localparam int HI_W     = ADDR_W - BYTE_W;
    localparam int RW_BIT   = BYTE_W - 3;
    localparam int FIFO_BIT = BYTE_W - 4;

    always_comb begin
        sel_o    = (cmd_i[BYTE_W-1 -: 2] == DEVSEL);
        read_o   = cmd_i[RW_BIT];
        fifo_o   = cmd_i[FIFO_BIT];
        hi_o     = cmd_i[HI_W-1:0];
        refuse_o = fifo_o && (!read_o || fifo_empty_i);
    end

endmodule

// File: rtl/hpx_slave.sv
module hpx_slave
    import hpx_pkg::*;
#(
    parameter int         PAIR_W = 2,
    parameter int         BYTE_W = 8,
    parameter logic [1:0] DEVSEL = 2'b01,
    localparam int        ADDR_W = 2 * BYTE_W - 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [PAIR_W-1:0] had_i,
    output logic [PAIR_W-1:0] had_o,
    output logic              had_oe_o,
    input  logic              ctl_i,
    output logic              ctl_o,
    output logic              ctl_oe_o,
    output logic              stop_o,
    input  logic              loc_busy_i,
    output logic [ADDR_W-1:0] reg_addr_o,
    output logic              reg_rd_o,
    input  logic [BYTE_W-1:0] reg_rdata_i,
    output logic              reg_wr_o,
    output logic [BYTE_W-1:0] reg_wdata_o,
    output logic              fifo_rd_o,
    input  logic [BYTE_W-1:0] fifo_data_i,
    input  logic              fifo_empty_i
);

    localparam int PHASE_CYC = BYTE_W / PAIR_W;
    localparam int CNT_W     = $clog2(PHASE_CYC);
    localparam int HI_W      = ADDR_W - BYTE_W;
    localparam int FIFO_BIT  = BYTE_W - 4;
    localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(PHASE_CYC - 1);
    localparam logic [CNT_W-1:0] RDY_IDX  = CNT_W'(1);
    localparam logic [CNT_W-1:0] MORE_IDX = CNT_W'(1);

    typedef struct packed {
        hpx_state_e        state;
        logic [CNT_W-1:0]  cnt;
        logic [BYTE_W-1:0] cmd;
        logic              stop;
        logic              rdy;
        logic              more;
        logic              wr;
        logic [BYTE_W-1:0] wdata;
    } slv_regs_t;

    slv_regs_t r_d, r_q;

    logic              sh_load, sh_shift;
    logic [BYTE_W-1:0] sh_val, sh_asm;
    logic [PAIR_W-1:0] sh_pair, sh_in;
    logic              ad_load, ad_inc;
    logic [ADDR_W-1:0] ad_q;
    logic              rd_reg, rd_fifo, go_data;
    logic              sel, is_read, is_fifo, refuse;
    logic [HI_W-1:0]   addr_hi;
    logic              last, ready_now, in_gate;

    hpx_cmd_dec #(
        .BYTE_W (BYTE_W),
        .ADDR_W (ADDR_W),
        .DEVSEL (DEVSEL)
    ) u_dec (
        .cmd_i        (r_q.cmd),
        .fifo_empty_i (fifo_empty_i),
        .sel_o        (sel),
        .read_o       (is_read),
        .fifo_o       (is_fifo),
        .hi_o         (addr_hi),
        .refuse_o     (refuse)
    );

    hpx_pair_shreg #(
        .PAIR_W (PAIR_W),
        .BYTE_W (BYTE_W)
    ) u_sh (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (sh_load),
        .load_val_i (sh_val),
        .shift_i    (sh_shift),
        .pair_i     (sh_in),
        .pair_o     (sh_pair),
        .asm_o      (sh_asm)
    );

    hpx_addr_ctr #(
        .ADDR_W (ADDR_W)
    ) u_addr (
        .clk        (clk),
        .rst_n      (rst_n),
        .load_i     (ad_load),
        .load_val_i ({addr_hi, sh_asm}),
        .inc_i      (ad_inc),
        .addr_o     (ad_q)
    );

    // Read data shifts zeros in behind the outgoing pairs; otherwise take the pad.
    assign sh_in = (r_q.state == ST_DATA && is_read) ? '0 : had_i;

    assign last      = (r_q.cnt == LAST_IDX);
    assign in_gate   = (r_q.state == ST_RETRY) || (r_q.state == ST_WAIT);
    assign ready_now = !loc_busy_i && !((r_q.state == ST_RETRY) && refuse);

    always_comb begin
        r_d      = r_q;
        r_d.wr   = 1'b0;
        sh_load  = 1'b0;
        sh_val   = '0;
        sh_shift = 1'b0;
        ad_load  = 1'b0;
        ad_inc   = r_q.wr;
        rd_reg   = 1'b0;
        rd_fifo  = 1'b0;
        go_data  = 1'b0;

        case (r_q.state)
            ST_IDLE: begin
                r_d.stop = 1'b0;
                r_d.cnt  = '0;
                if (ctl_i) begin
                    sh_shift  = 1'b1;
                    r_d.cnt   = CNT_W'(1);
                    r_d.state = ST_CMD;
                end
            end
            ST_CMD: begin
                if (!ctl_i) begin
                    r_d.state = ST_IDLE;
                    r_d.cnt   = '0;
                end else begin
                    sh_shift = 1'b1;
                    r_d.cnt  = r_q.cnt + 1'b1;
                    if (last) begin
                        r_d.cmd   = sh_asm;
                        r_d.cnt   = '0;
                        r_d.state = sh_asm[FIFO_BIT] ? ST_DEC : ST_ADDR;
                    end
                end
            end
            ST_ADDR: begin
                sh_shift = 1'b1;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (last) begin
                    ad_load   = 1'b1;
                    r_d.cnt   = '0;
                    r_d.state = ST_DEC;
                end
            end
            ST_DEC: begin
                r_d.cnt   = '0;
                r_d.state = sel ? ST_RETRY : ST_IDLE;
            end
            ST_RETRY, ST_WAIT: begin
                r_d.cnt = r_q.cnt + 1'b1;
                if (r_q.cnt == RDY_IDX) begin
                    r_d.stop = (r_q.state == ST_RETRY) && refuse;
                    r_d.rdy  = ready_now;
                end
                if (last) begin
                    r_d.cnt = '0;
                    if (r_q.stop) begin
                        r_d.stop  = 1'b0;
                        r_d.state = ST_IDLE;
                    end else if (r_q.rdy) begin
                        go_data = 1'b1;
                    end else begin
                        r_d.state = ST_WAIT;
                    end
                end
            end
            ST_DATA: begin
                sh_shift = 1'b1;
                r_d.cnt  = r_q.cnt + 1'b1;
                if (r_q.cnt == MORE_IDX) begin
                    r_d.more = ctl_i;
                end
                if (last) begin
                    r_d.cnt = '0;
                    if (!is_read) begin
                        r_d.wr    = !is_fifo;
                        r_d.wdata = sh_asm;
                    end
                    if (r_q.more) begin
                        if (loc_busy_i) begin
                            r_d.state = ST_WAIT;
                        end else begin
                            go_data = 1'b1;
                        end
                    end else begin
                        r_d.state = is_read ? ST_TA : ST_IDLE;
                    end
                end
            end
            ST_TA: begin
                r_d.cnt   = '0;
                r_d.state = ST_IDLE;
            end
            default: begin
                r_d.state = ST_IDLE;
            end
        endcase

        if (go_data) begin
            r_d.state = ST_DATA;
            if (is_read) begin
                sh_load = 1'b1;
                if (is_fifo) begin
                    rd_fifo = 1'b1;
                    sh_val  = fifo_data_i;
                end else begin
                    rd_reg = 1'b1;
                    ad_inc = 1'b1;
                    sh_val = reg_rdata_i;
                end
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign had_o       = sh_pair;
    assign had_oe_o    = is_read && ((r_q.state == ST_DATA) || (r_q.state == ST_WAIT));
    assign ctl_o       = 1'b0;
    assign ctl_oe_o    = in_gate && (r_q.cnt == RDY_IDX) && ready_now;
    assign stop_o      = r_q.stop;
    assign reg_addr_o  = ad_q;
    assign reg_rd_o    = rd_reg;
    assign reg_wr_o    = r_q.wr;
    assign reg_wdata_o = r_q.wdata;
    assign fifo_rd_o   = rd_fifo;

endmodule

// File: rtl/hpx_slave_chk.sv
module hpx_slave_chk #(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst_n,
    input logic              had_oe_o,
    input logic              ctl_o,
    input logic              ctl_oe_o,
    input logic              stop_o,
    input logic              reg_rd_o,
    input logic              reg_wr_o,
    input logic              fifo_rd_o,
    input logic [ADDR_W-1:0] reg_addr_o
);

    AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        stop_o |-> !had_oe_o && !ctl_oe_o && !reg_rd_o && !fifo_rd_o && !reg_wr_o); // R5

    AST_STOP_TWO_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(stop_o) |=> stop_o); // R5

    AST_STOP_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_o && $past(stop_o)) |=> !stop_o); // R5

    AST_READY_PULLS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        ctl_oe_o |-> !ctl_o); // R6

    AST_WR_ONE_CLK: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> !reg_wr_o); // R8

    AST_WR_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        reg_wr_o |=> (reg_addr_o == $past(reg_addr_o) + 1'b1)); // R9

    AST_READ_DRIVES: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_rd_o || fifo_rd_o) |=> had_oe_o); // R7

    AST_TA_RELEASED: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(had_oe_o) |=> !had_oe_o); // R10

    AST_POP_EXCL: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_rd_o && fifo_rd_o)); // R11

endmodule

bind hpx_slave hpx_slave_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .had_oe_o   (had_oe_o),
    .ctl_o      (ctl_o),
    .ctl_oe_o   (ctl_oe_o),
    .stop_o     (stop_o),
    .reg_rd_o   (reg_rd_o),
    .reg_wr_o   (reg_wr_o),
    .fifo_rd_o  (fifo_rd_o),
    .reg_addr_o (reg_addr_o)
);

// File: tb/tb_hpx_slave.sv
`timescale 1ns/1ps
module tb_hpx_slave;

    localparam int CLK_P = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [1:0]  had_i = 2'b00;
    logic [1:0]  had_o;
    logic        had_oe_o;
    logic        ctl_i = 1'b0;
    logic        ctl_o, ctl_oe_o, stop_o;
    logic        loc_busy_i = 1'b0;
    logic [11:0] reg_addr_o;
    logic        reg_rd_o, reg_wr_o, fifo_rd_o;
    logic [7:0]  reg_rdata_i, reg_wdata_o, fifo_data_i;
    logic        fifo_empty_i;

    logic [7:0]  mem [4096];
    logic [7:0]  fifo_mem [16];
    logic [3:0]  fifo_wp = 4'd0;
    logic [3:0]  fifo_rp = 4'd0;
    logic [19:0] wr_exp_q [$];

    int checks = 0;
    int errors = 0;

    logic [1:0] s_had;
    logic       s_oe, s_ctl_oe, s_ctl, s_stop, s_any_strobe;

    always #(CLK_P/2) clk = ~clk;

    hpx_slave dut (
        .clk          (clk),
        .rst_n        (rst_n),
        .had_i        (had_i),
        .had_o        (had_o),
        .had_oe_o     (had_oe_o),
        .ctl_i        (ctl_i),
        .ctl_o        (ctl_o),
        .ctl_oe_o     (ctl_oe_o),
        .stop_o       (stop_o),
        .loc_busy_i   (loc_busy_i),
        .reg_addr_o   (reg_addr_o),
        .reg_rd_o     (reg_rd_o),
        .reg_rdata_i  (reg_rdata_i),
        .reg_wr_o     (reg_wr_o),
        .reg_wdata_o  (reg_wdata_o),
        .fifo_rd_o    (fifo_rd_o),
        .fifo_data_i  (fifo_data_i),
        .fifo_empty_i (fifo_empty_i)
    );

    assign reg_rdata_i  = mem[reg_addr_o];
    assign fifo_data_i  = fifo_mem[fifo_rp];
    assign fifo_empty_i = (fifo_rp == fifo_wp);

    function automatic logic [7:0] pat(input logic [11:0] a);
        return a[7:0] ^ {a[11:8], a[11:8]} ^ 8'h5A;
    endfunction

    // Local-side memory and FIFO models.
    always @(posedge clk) begin
        if (reg_wr_o) mem[reg_addr_o] <= reg_wdata_o;
        if (fifo_rd_o) fifo_rp <= fifo_rp + 4'd1;
    end

    task automatic chk(input logic ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
        end
    endtask

    // Scoreboard monitor: every register write strobe is matched against the queue.
    always @(negedge clk) begin
        if (rst_n && reg_wr_o) begin
            if (wr_exp_q.size() == 0) begin
                chk(1'b0, "R8 unexpected write", {reg_addr_o, reg_wdata_o}, 32'h0);
            end else begin
                logic [19:0] e;
                e = wr_exp_q.pop_front();
                chk({reg_addr_o, reg_wdata_o} == e, "R8/R9 write addr,data",
                    {reg_addr_o, reg_wdata_o}, e);
            end
        end
    end

    task automatic cyc(input logic [1:0] h, input logic c);
        had_i = h;
        ctl_i = c;
        @(negedge clk);
        s_had        = had_o;
        s_oe         = had_oe_o;
        s_ctl_oe     = ctl_oe_o;
        s_ctl        = ctl_o;
        s_stop       = stop_o;
        s_any_strobe = reg_rd_o | reg_wr_o | fifo_rd_o;
        @(posedge clk);
        #1;
    endtask

    task automatic send_byte(input logic [7:0] b, input logic c);
        for (int k = 0; k < 4; k++) begin
            cyc(b[7-2*k -: 2], c);
            chk(!s_oe, "R7 no drive in cmd/addr", s_oe, 0);
        end
    endtask

    // One master transfer. wbuf holds write bytes; waits0 busy retry/wait phases
    // before the first byte; mid_at = index of the byte preceded by one wait.
    logic [7:0] wbuf [8];

    task automatic xfer(input logic [7:0] cmd, input logic [7:0] ext, input int n,
                        input int waits0, input int mid_at);
        logic        rd, ff, sel, exp_stop, rdy;
        logic [11:0] base;
        logic [3:0]  f0;
        logic [7:0]  got, exp;
        int          w;
        rd   = cmd[5];
        ff   = cmd[4];
        sel  = (cmd[7:6] == 2'b01);
        base = {cmd[3:0], ext};
        f0   = fifo_rp;
        loc_busy_i = 1'b0;
        send_byte(cmd, 1'b1);
        if (!ff) send_byte(ext, 1'b0);
        cyc(2'b00, 1'b0);
        chk(!s_oe && !s_ctl_oe && !s_stop, "R4 decode clock quiet", {s_oe, s_ctl_oe, s_stop}, 0);
        if (!sel) begin
            for (int k = 0; k < 6; k++) begin
                cyc(2'b00, 1'b0);
                chk(!s_oe && !s_ctl_oe && !s_stop && !s_any_strobe, "R2 unselected stays quiet",
                    {s_oe, s_ctl_oe, s_stop, s_any_strobe}, 0);
            end
            return;
        end
        exp_stop = ff && (!rd || fifo_empty_i);
        w = 0;
        rdy = 1'b0;
        while (!rdy && w < 8) begin
            loc_busy_i = (w < waits0);
            for (int k = 0; k < 4; k++) begin
                cyc(2'b00, 1'b0);
                if (k == 1) rdy = s_ctl_oe && !s_ctl;
                if (k == 1 && w > 0 && rd) chk(s_oe, "R7 read wait phase driven", s_oe, 1);
                if (exp_stop && k >= 2) chk(s_stop, "R5 stop in retry clocks 3-4", s_stop, 1);
                if (exp_stop) chk(!s_any_strobe && !s_oe, "R5 no data on stop", s_any_strobe, 0);
            end
            if (exp_stop) begin
                chk(!rdy, "R5 stop overrides ready", rdy, 0);
                loc_busy_i = 1'b0;
                cyc(2'b00, 1'b0);
                chk(!s_stop && !s_oe, "R5 back to idle", s_stop, 0);
                return;
            end
            chk(rdy == (w >= waits0), "R6 ready vs busy", rdy, (w >= waits0));
            w++;
        end
        loc_busy_i = 1'b0;
        for (int i = 0; i < n; i++) begin
            got = 8'h00;
            exp = ff ? fifo_mem[f0 + 4'(i)] : mem[base + 12'(i)];
            if (!rd) wr_exp_q.push_back({base + 12'(i), wbuf[i]});
            for (int k = 0; k < 4; k++) begin
                if (k == 3) loc_busy_i = (i + 1 == mid_at);
                cyc(rd ? 2'b00 : wbuf[i][7-2*k -: 2], (k == 1) && (i < n - 1));
                if (rd) begin
                    got = {got[5:0], s_had};
                    chk(s_oe, "R7 read data driven", s_oe, 1);
                end else begin
                    chk(!s_oe, "R7 no drive on write", s_oe, 0);
                end
            end
            if (rd) chk(got == exp, ff ? "R11 fifo byte" : "R9 read byte", got, exp);
            if (i + 1 == mid_at && i < n - 1) begin
                loc_busy_i = 1'b0;
                for (int k = 0; k < 4; k++) begin
                    cyc(2'b00, 1'b0);
                    if (k == 1) chk(s_ctl_oe, "R9 wait before next byte, ready", s_ctl_oe, 1);
                    if (rd) chk(s_oe, "R7 mid wait driven", s_oe, 1);
                end
            end
        end
        loc_busy_i = 1'b0;
        if (rd) begin
            cyc(2'b00, 1'b0);
            chk(!s_oe, "R10 turnaround released", s_oe, 0);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        for (int a = 0; a < 4096; a++) mem[a] = pat(12'(a));
        for (int a = 0; a < 16; a++) fifo_mem[a] = 8'h00;
        repeat (3) @(posedge clk);
        #1;
        cyc(2'b00, 1'b0);
        chk(!s_oe && !s_ctl_oe && !s_stop && !s_any_strobe, "R7 reset outputs quiet",
            {s_oe, s_ctl_oe, s_stop, s_any_strobe}, 0);
        rst_n = 1'b1;
        cyc(2'b00, 1'b0);

        // R8 R9: three-byte register write across the 8-bit boundary.
        wbuf[0] = 8'hA5; wbuf[1] = 8'h3C; wbuf[2] = 8'hF0;
        xfer(8'h41, 8'hFE, 3, 0, -1);
        // R3 R6 R7: read back with two busy phases first.
        xfer(8'h61, 8'hFE, 3, 2, -1);
        // R3: single read of untouched location.
        xfer(8'h60, 8'hA3, 1, 0, -1);
        // R9: write and read with a wait inserted before the second byte.
        wbuf[0] = 8'h11; wbuf[1] = 8'hEE;
        xfer(8'h47, 8'h00, 2, 0, 1);
        xfer(8'h67, 8'h00, 2, 1, 1);

        // R11: FIFO reads.
        fifo_mem[0] = 8'h9C; fifo_mem[1] = 8'h07; fifo_mem[2] = 8'hD2;
        fifo_wp = 4'd3;
        xfer(8'h70, 8'h00, 2, 0, -1);
        xfer(8'h70, 8'h00, 1, 1, -1);
        chk(fifo_rp == 4'd3, "R11 one pop per byte", fifo_rp, 3);
        // R5: empty FIFO read with local side idle, then FIFO write.
        xfer(8'h70, 8'h00, 1, 0, -1);
        chk(fifo_rp == 4'd3, "R5 no pop on refusal", fifo_rp, 3);
        xfer(8'h50, 8'h00, 1, 0, -1);

        // R2: wrong device select on a write, then confirm memory untouched.
        wbuf[0] = 8'h00;
        xfer(8'h81, 8'hFF, 1, 0, -1);
        xfer(8'h21, 8'hFF, 1, 0, -1);
        chk(mem[12'h1FF] == 8'h3C, "R2 unselected write ignored", mem[12'h1FF], 8'h3C);

        // R1: command abandoned after two clocks, then quiet, then a good read.
        cyc(2'b01, 1'b1);
        cyc(2'b10, 1'b1);
        for (int k = 0; k < 8; k++) begin
            cyc(2'b11, 1'b0);
            chk(!s_oe && !s_ctl_oe && !s_stop && !s_any_strobe, "R1 abandoned command quiet",
                {s_oe, s_ctl_oe, s_stop, s_any_strobe}, 0);
        end
        xfer(8'h61, 8'hFD, 5, 0, -1);

        // R8: byte-accurate register contents.
        chk(mem[12'h1FD] == pat(12'h1FD), "R8 neighbour below", mem[12'h1FD], pat(12'h1FD));
        chk(mem[12'h1FE] == 8'hA5, "R8 byte 0", mem[12'h1FE], 8'hA5);
        chk(mem[12'h1FF] == 8'h3C, "R8 byte 1", mem[12'h1FF], 8'h3C);
        chk(mem[12'h200] == 8'hF0, "R9 byte 2 after carry", mem[12'h200], 8'hF0);
        chk(mem[12'h201] == pat(12'h201), "R8 neighbour above", mem[12'h201], pat(12'h201));
        chk(mem[12'h700] == 8'h11 && mem[12'h701] == 8'hEE, "R9 waited write",
            {mem[12'h700], mem[12'h701]}, 16'h11EE);
        chk(wr_exp_q.size() == 0, "R8 all writes seen", wr_exp_q.size(), 0);

        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule